// File: doc/BRIEF.md
# Asynchronous Word Framer with Buffered Serial Readout

This block sits behind a 1200 baud demodulator and turns its recovered bit stream into framed words. It looks for a start bit, confirms it at half a bit time, then samples eight data bits and one stop bit at the centre of each bit period. `BIT_CLKS` core clocks make up one bit. The default of 2983 suits a core clock of about 3.58 MHz.

Two output interfaces are selected by `mode_buf`:
- **Stream interface (`mode_buf` = 0):** the incoming bits go straight to `data_out`, delayed by one register. The block also drives `sclk_out`, whose rising edge marks the centre of each data bit and of the stop bit.
- **Buffered interface (`mode_buf` = 1):** the start bit is dropped. The eight data bits and the stop bit are kept in a 9-bit holding register. An external controller reads them out by raising `rd_clk_in` once per bit.

In both interfaces the active-low `ready_n` strobe marks the end of each word. When `enable` is low, the block is held idle.

Top module: `fwf_word_framer`

## Requirements
- R1: While `rst` is high or `enable` is low, the outputs sit idle from the next clock edge: `ready_n` = 1, `data_out` = 1, `sclk_out` = 0.
- R2: With `mode_buf` = 0 and `enable` = 1, `data_out` equals `rx_bit` as sampled at the previous clock edge.
- R3: With `mode_buf` = 0, `sclk_out` rises exactly 9 times per word. Each rise falls at the centre sample of data bits 0..7 and then of the stop bit, and `sclk_out` stays high for `BIT_CLKS/2` clocks. At each rise, `data_out` holds that bit. With `mode_buf` = 1, `sclk_out` stays 0.
- R4: A start is triggered by a high-to-low change of `rx_bit`. It is accepted only if `rx_bit` is still 0 when sampled `BIT_CLKS/2` clocks later. A shorter low pulse produces no word: no `ready_n` pulse and no `sclk_out` edge.
- R5: One clock after the stop bit is sampled, `ready_n` goes low for exactly `BIT_CLKS/2` clocks and then returns high. This holds in both interfaces, unless R8 ends it earlier.
- R6: With `mode_buf` = 1, each rising edge of `rd_clk_in` puts the next held bit on `data_out`. The order is least significant data bit first, and the ninth edge gives the stop bit as received, even when it is 0.
- R7: With `mode_buf` = 1, rising edges of `rd_clk_in` after the ninth one put logic 1 on `data_out` until a new word is loaded.
- R8: With `mode_buf` = 1, a rising edge of `rd_clk_in` while `ready_n` is low returns `ready_n` high within 4 clocks. `rd_clk_in` passes through a 2-stage synchronizer and an edge detector.
- R9: Dropping `enable` in the middle of a word abandons that word. After `enable` returns with the line high, no `ready_n` pulse for the abandoned word appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High to run; low holds the block idle |
| mode_buf | input | 1 | 0 selects the stream interface, 1 the buffered interface |
| rx_bit | input | 1 | Demodulated line bit (1 = mark, 0 = space) |
| rd_clk_in | input | 1 | Read clock from the controller, used in buffered mode, asynchronous |
| data_out | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated bit clock, stream mode only |
| ready_n | output | 1 | Active-low end-of-word strobe |

## Verification
A wrong bit counter or a wrong shift order in the framer shows up within one word. In stream mode it appears as a wrong number of `sclk_out` rises or as wrong values captured at those rises. In buffered mode it appears as a wrong bit on some of the nine reads. A half-bit counter that is off by one changes the measured width of `ready_n` right away. The same error in the start check makes a short glitch produce a spurious strobe about ten bit times later. A stuck synchronizer or edge detector shows up within a few clocks of the first read edge, because `ready_n` then stays low when it should have cleared.

// File: rtl/fwf_pkg.sv
package fwf_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_t;
endpackage

// File: rtl/fwf_edge_sync.sv
module fwf_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst || !enable) sq[0] <= 1'b0;
          else                sq[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst || !enable) sq[g] <= 1'b0;
          else                sq[g] <= sq[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !enable) last_q <= 1'b0;
    else                last_q <= sq[STAGES-1];
  end

  assign rise = sq[STAGES-1] & ~last_q;
endmodule

// File: rtl/fwf_framer.sv
module fwf_framer
  import fwf_pkg::*;
#(
  parameter int BIT_CLKS  = 2983,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 mode_buf,
  input  logic                 rx_bit,
  output logic                 word_done,
  output logic [DATA_BITS:0]   word_bits,
  output logic                 sclk_out
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS + 1);
  localparam int IW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

  fr_state_t         state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     hcnt;
  logic [IW-1:0]     idx;
  logic [DATA_BITS:0] shreg;
  logic              rx_prev;
  logic              sclk_q;
  logic              sample_now;

  assign sample_now = ((state == FR_DATA) || (state == FR_STOP)) && (cnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state     <= FR_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      rx_prev   <= 1'b1;
      word_done <= 1'b0;
    end else begin
      rx_prev   <= rx_bit;
      word_done <= 1'b0;
      case (state)
        FR_IDLE: begin
          if (rx_prev && !rx_bit) begin
            state <= FR_START;
            cnt   <= '0;
          end
        end
        FR_START: begin
          if (cnt == HALF_LAST) begin
            cnt <= '0;
            idx <= '0;
            state <= rx_bit ? FR_IDLE : FR_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        FR_DATA: begin
          if (cnt == BIT_LAST) begin
            cnt   <= '0;
            shreg <= {rx_bit, shreg[DATA_BITS:1]};
            if (idx == IDX_LAST) state <= FR_STOP;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        FR_STOP: begin
          if (cnt == BIT_LAST) begin
            cnt       <= '0;
            shreg     <= {rx_bit, shreg[DATA_BITS:1]};
            word_done <= 1'b1;
            state     <= FR_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  // Bit clock for the stream interface: high for half a bit from each sample.
  always_ff @(posedge clk) begin
    if (rst || !enable || mode_buf) begin
      sclk_q <= 1'b0;
      hcnt   <= '0;
    end else if (sample_now) begin
      sclk_q <= 1'b1;
      hcnt   <= HALF_LAST;
    end else if (hcnt != '0) begin
      hcnt <= hcnt - 1'b1;
    end else begin
      sclk_q <= 1'b0;
    end
  end

  assign word_bits = shreg;
  assign sclk_out  = sclk_q;
endmodule

// File: rtl/fwf_readout.sv
module fwf_readout #(
  parameter int DATA_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               mode_buf,
  input  logic               rx_bit,
  input  logic               load,
  input  logic [DATA_BITS:0] word_bits,
  input  logic               rd_edge,
  output logic               data_out
);
  logic [DATA_BITS:0] hold_q;
  logic               data_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      hold_q <= '1;
    end else if (load && mode_buf) begin
      hold_q <= word_bits;
    end else if (rd_edge && mode_buf) begin
      hold_q <= {1'b1, hold_q[DATA_BITS:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable)  data_q <= 1'b1;
    else if (!mode_buf)  data_q <= rx_bit;
    else if (rd_edge)    data_q <= hold_q[0];
  end

  assign data_out = data_q;
endmodule

// File: rtl/fwf_ready.sv
module fwf_ready #(
  parameter int BIT_CLKS = 2983
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic mode_buf,
  input  logic word_done,
  input  logic rd_edge,
  output logic ready_n
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic [CW-1:0] lcnt;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      rdy_q <= 1'b1;
      lcnt  <= '0;
    end else if (word_done) begin
      rdy_q <= 1'b0;
      lcnt  <= HALF_LAST;
    end else if (!rdy_q) begin
      if (mode_buf && rd_edge) begin
        rdy_q <= 1'b1;
        lcnt  <= '0;
      end else if (lcnt == '0) begin
        rdy_q <= 1'b1;
      end else begin
        lcnt <= lcnt - 1'b1;
      end
    end
  end

  assign ready_n = rdy_q;
endmodule

// File: rtl/fwf_word_framer.sv
module fwf_word_framer #(
  parameter int BIT_CLKS    = 2983,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic mode_buf,
  input  logic rx_bit,
  input  logic rd_clk_in,
  output logic data_out,
  output logic sclk_out,
  output logic ready_n
);
  logic               rd_edge;
  logic               word_done;
  logic [DATA_BITS:0] word_bits;

  fwf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .enable(enable),
    .async_in(rd_clk_in), .rise(rd_edge)
  );

  fwf_framer #(.BIT_CLKS(BIT_CLKS), .DATA_BITS(DATA_BITS)) u_framer (
    .clk(clk), .rst(rst), .enable(enable), .mode_buf(mode_buf),
    .rx_bit(rx_bit), .word_done(word_done), .word_bits(word_bits),
    .sclk_out(sclk_out)
  );

  fwf_readout #(.DATA_BITS(DATA_BITS)) u_readout (
    .clk(clk), .rst(rst), .enable(enable), .mode_buf(mode_buf),
    .rx_bit(rx_bit), .load(word_done), .word_bits(word_bits),
    .rd_edge(rd_edge), .data_out(data_out)
  );

  fwf_ready #(.BIT_CLKS(BIT_CLKS)) u_ready (
    .clk(clk), .rst(rst), .enable(enable), .mode_buf(mode_buf),
    .word_done(word_done), .rd_edge(rd_edge), .ready_n(ready_n)
  );
endmodule

// File: rtl/fwf_word_framer_chk.sv
module fwf_word_framer_chk #(
  parameter int BIT_CLKS = 2983
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic mode_buf,
  input logic rx_bit,
  input logic data_out,
  input logic sclk_out,
  input logic ready_n
);
  localparam int HALF = BIT_CLKS / 2;

  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= ready_n  ? 32'd0 : low_run + 32'd1;
      high_run <= sclk_out ? high_run + 32'd1 : 32'd0;
    end
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (ready_n && data_out && !sclk_out));

  // R2
  stream_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !mode_buf) |=> (data_out == $past(rx_bit)));

  // R3
  no_sclk_buffered_chk: assert property (@(posedge clk) disable iff (rst)
    mode_buf |=> !sclk_out);

  // R3
  sclk_width_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_out |-> (high_run < HALF));

  // R5
  ready_width_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_n |-> (low_run < HALF));
endmodule

bind fwf_word_framer fwf_word_framer_chk #(.BIT_CLKS(BIT_CLKS)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .mode_buf(mode_buf),
  .rx_bit(rx_bit), .data_out(data_out), .sclk_out(sclk_out),
  .ready_n(ready_n)
);

// File: tb/fwf_word_framer_test.sv
module fwf_word_framer_test;
  localparam int B    = 20;
  localparam int HALF = B / 2;
  // {mode_buf, stop bit, data byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'h01},
    {1'b1, 1'b1, 8'h5A}, {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1, enable = 1'b0, mode_buf = 1'b0, rx_bit = 1'b1, rd_clk_in = 1'b0;
  logic data_out, sclk_out, ready_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // monitor state
  logic       sclk_prev = 1'b0, ready_prev = 1'b1;
  logic [8:0] cap = '0;
  int         cap_n = 0, low_cnt = 0, last_low = 0, ready_falls = 0;

  logic       cur_mode, cur_stop;
  logic [7:0] cur_byte;
  int         falls0;

  always #2.5 clk = ~clk;

  fwf_word_framer #(.BIT_CLKS(B)) uut (
    .clk(clk), .rst(rst), .enable(enable), .mode_buf(mode_buf),
    .rx_bit(rx_bit), .rd_clk_in(rd_clk_in), .data_out(data_out),
    .sclk_out(sclk_out), .ready_n(ready_n)
  );

  always @(negedge clk) begin
    if (sclk_out && !sclk_prev) begin
      cap   <= {data_out, cap[8:1]};
      cap_n <= cap_n + 1;
    end
    sclk_prev <= sclk_out;
    if (!ready_n && ready_prev) ready_falls <= ready_falls + 1;
    if (!ready_n) low_cnt <= low_cnt + 1;
    else if (low_cnt != 0) begin
      last_low <= low_cnt;
      low_cnt  <= 0;
    end
    ready_prev <= ready_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bits(input logic [7:0] b);
    rx_bit = 1'b0;
    hold(B);
    for (int i = 0; i < 8; i++) begin
      rx_bit = b[i];
      hold(B);
    end
  endtask

  task automatic read_pulse();
    rd_clk_in = 1'b1;
    hold(5);
    rd_clk_in = 1'b0;
    hold(3);
  endtask

  initial begin
    hold(4);
    // R1: reset state
    chk("R1 ready_n in reset", 32'(ready_n), 32'd1);
    chk("R1 data_out in reset", 32'(data_out), 32'd1);
    chk("R1 sclk_out in reset", 32'(sclk_out), 32'd0);
    rst = 1'b0;
    enable = 1'b1;
    hold(4);

    // R2: stream follows line with one register of delay (short lows)
    rx_bit = 1'b0;
    hold(1);
    chk("R2 follow low", 32'(data_out), 32'd0);
    rx_bit = 1'b1;
    hold(1);
    chk("R2 follow high", 32'(data_out), 32'd1);

    // R4: glitch shorter than half a bit is rejected
    falls0 = ready_falls;
    rx_bit = 1'b0;
    hold(HALF - 2);
    rx_bit = 1'b1;
    hold(12 * B);
    chk("R4 glitch no strobe", 32'(ready_falls), 32'(falls0));
    chk("R4 glitch no sclk", 32'(cap_n), 32'd0);

    // table of words
    for (int k = 0; k < 6; k++) begin
      {cur_mode, cur_stop, cur_byte} = VEC[k];
      mode_buf = cur_mode;
      hold(4);
      cap_n = 0;
      last_low = 0;
      drive_bits(cur_byte);
      rx_bit = cur_stop;
      for (int w = 0; w < 3 * B && ready_n; w++) hold(1);
      chk("R5 strobe asserted", 32'(ready_n), 32'd0);
      if (cur_mode) begin
        read_pulse();
        chk("R8 first read clears strobe", 32'(ready_n), 32'd1);
        chk("R6 bit0", 32'(data_out), 32'(cur_byte[0]));
        rx_bit = 1'b1;
        for (int i = 1; i < 8; i++) begin
          read_pulse();
          chk("R6 data bit", 32'(data_out), 32'(cur_byte[i]));
        end
        read_pulse();
        chk("R6 ninth read stop bit", 32'(data_out), 32'(cur_stop));
        read_pulse();
        chk("R7 extra read gives one", 32'(data_out), 32'd1);
        chk("R3 no sclk in buffered mode", 32'(cap_n), 32'd0);
      end else begin
        rx_bit = 1'b1;
        hold(2 * B);
        chk("R3 sclk rises per word", 32'(cap_n), 32'd9);
        chk("R3 bits at sclk rises", 32'(cap), 32'({cur_stop, cur_byte}));
        chk("R5 strobe width", 32'(last_low), 32'(HALF));
      end
      hold(B);
    end

    // R9: abandon a word by dropping enable
    mode_buf = 1'b0;
    hold(4);
    falls0 = ready_falls;
    rx_bit = 1'b0;
    hold(B + HALF);
    rx_bit = 1'b1;
    hold(2 * B);
    enable = 1'b0;
    hold(2);
    chk("R1 idle ready_n when disabled", 32'(ready_n), 32'd1);
    chk("R1 idle data_out when disabled", 32'(data_out), 32'd1);
    chk("R1 idle sclk_out when disabled", 32'(sclk_out), 32'd0);
    enable = 1'b1;
    hold(12 * B);
    chk("R9 abandoned word no strobe", 32'(ready_falls), 32'(falls0));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule